// File: doc/BRIEF.md
# Registered I/O Macrocell with Term-Driven Set, Reset and Clock

This cell is one output slice of a small registered programmable logic device. A group of product terms, already formed by the AND array, is ORed together and the sum is XORed with one dedicated polarity term. The result feeds a state register whose clock, set and reset are themselves product terms. No free-running clock and no global reset are involved. When the set and reset terms are both active, the register becomes transparent and its D value goes straight to the pin.

A second register samples the I/O pin, and it has its own clock, set and reset terms. The pin is modelled as separate in, out and enable ports. The enable comes from either a shared global input or the cell's own enable term. A configuration bit chooses which register feeds back to the array, and the feedback is offered in true and complement form. When the output driver is off, the pin can serve as an input through the second register.

Top module: `pld_io_cell`

## Requirements
- R1: The state register's D value is the OR of all `sopTerms` bits XORed with `xorTerm`. A rising edge on `stClkTerm` stores it, and `pinOut` then shows it.
- R2: With `stSetTerm`=1 and `stRstTerm`=0, `pinOut` becomes 1 at once without a clock. With `stRstTerm`=1 and `stSetTerm`=0, it becomes 0. While exactly one of the two is active, `stClkTerm` edges do not change the stored value.
- R3: With `stSetTerm`=1 and `stRstTerm`=1, `pinOut` follows the D value of R1 combinationally, and a `stClkTerm` edge stores D. If one term is dropped, the term still active takes effect. If both are dropped together, the stored value is kept.
- R4: The feedback register follows the rules of R1 to R3, using `pinIn` as D and `fbClkTerm`, `fbSetTerm` and `fbRstTerm`.
- R5: When `cfgGlobalOe`=1, `pinOe` equals `globalOe`. When `cfgGlobalOe`=0, `pinOe` equals `oeTerm`.
- R6: With `pinOe`=0, the feedback register still captures `pinIn`, so the pin works as an input.
- R7: With `cfgFbFromPin`=1, `fbOut` is the feedback register's output, including its bypass value. With `cfgFbFromPin`=0, `fbOut` equals `pinOut`.
- R8: `fbOutN` is always the inverse of `fbOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sopTerms | input | NUM_SOP | Sum-of-products inputs; unused ones tied low |
| xorTerm | input | 1 | Polarity / toggle term XORed into D |
| stClkTerm | input | 1 | State register clock term (rising edge) |
| stSetTerm | input | 1 | State register set term |
| stRstTerm | input | 1 | State register reset term |
| fbClkTerm | input | 1 | Pin register clock term (rising edge) |
| fbSetTerm | input | 1 | Pin register set term |
| fbRstTerm | input | 1 | Pin register reset term |
| oeTerm | input | 1 | Local output enable term |
| globalOe | input | 1 | Shared output enable pin |
| cfgGlobalOe | input | 1 | 1: use globalOe, 0: use oeTerm |
| cfgFbFromPin | input | 1 | 1: feed back pin register, 0: state register |
| pinIn | input | 1 | Value seen on the I/O pin |
| pinOut | output | 1 | Value driven onto the pin |
| pinOe | output | 1 | Pin driver enable |
| fbOut | output | 1 | Feedback to the array, true form |
| fbOutN | output | 1 | Feedback to the array, complement form |

## Verification
The bench builds the cell with NUM_SOP=5. At that size it can raise each sum term alone, both with and without the XOR term, so a term missing from the OR or a wrong polarity shows up directly. It walks set-only, reset-only and bypass on both registers, including the two ways of leaving bypass. It drives clock edges while a force term is active, and it compares every output against a behavioural model on every cycle.

// File: rtl/pld_io_cell_pkg.sv
package pld_io_cell_pkg;
  typedef struct packed {
    logic stHi;
    logic stLo;
    logic stByp;
    logic fbHi;
    logic fbLo;
    logic fbByp;
    logic oeEn;
    logic fbSel;
  } cellStrobes_t;
endpackage

// File: rtl/pld_io_cell_ctrl.sv
module pld_io_cell_ctrl
  import pld_io_cell_pkg::*;
(
  input  logic         stSetTerm,
  input  logic         stRstTerm,
  input  logic         fbSetTerm,
  input  logic         fbRstTerm,
  input  logic         oeTerm,
  input  logic         globalOe,
  input  logic         cfgGlobalOe,
  input  logic         cfgFbFromPin,
  output cellStrobes_t strobes
);
  always_comb begin
    strobes.stHi  = stSetTerm & ~stRstTerm;
    strobes.stLo  = stRstTerm & ~stSetTerm;
    strobes.stByp = stSetTerm & stRstTerm;
    strobes.fbHi  = fbSetTerm & ~fbRstTerm;
    strobes.fbLo  = fbRstTerm & ~fbSetTerm;
    strobes.fbByp = fbSetTerm & fbRstTerm;
    strobes.oeEn  = cfgGlobalOe ? globalOe : oeTerm;
    strobes.fbSel = cfgFbFromPin;
  end
endmodule

// File: rtl/pld_io_cell_reg.sv
module pld_io_cell_reg (
  input  logic clkTerm,
  input  logic forceHi,
  input  logic forceLo,
  input  logic bypass,
  input  logic d,
  output logic q
);
  logic stored;

  always_ff @(posedge clkTerm or posedge forceHi or posedge forceLo) begin
    if (forceHi)      stored <= 1'b1;
    else if (forceLo) stored <= 1'b0;
    else              stored <= d;
  end

  assign q = bypass ? d : stored;
endmodule

// File: rtl/pld_io_cell_dp.sv
module pld_io_cell_dp
  import pld_io_cell_pkg::*;
#(
  parameter int NUM_SOP = 8
) (
  input  logic [NUM_SOP-1:0] sopTerms,
  input  logic               xorTerm,
  input  logic               stClkTerm,
  input  logic               fbClkTerm,
  input  logic               pinIn,
  input  cellStrobes_t       strobes,
  output logic               pinOut,
  output logic               pinOe,
  output logic               fbOut,
  output logic               fbOutN
);
  localparam int NUM_REGS = 2;
  localparam int ST_IDX   = 0;
  localparam int FB_IDX   = 1;

  logic sumOfTerms;
  logic [NUM_REGS-1:0] regClk, regHi, regLo, regByp, regD, regQ;

  assign sumOfTerms = |sopTerms;

  assign regClk = {fbClkTerm, stClkTerm};
  assign regHi  = {strobes.fbHi,  strobes.stHi};
  assign regLo  = {strobes.fbLo,  strobes.stLo};
  assign regByp = {strobes.fbByp, strobes.stByp};
  assign regD   = {pinIn, sumOfTerms ^ xorTerm};

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    pld_io_cell_reg uReg (
      .clkTerm (regClk[g]),
      .forceHi (regHi[g]),
      .forceLo (regLo[g]),
      .bypass  (regByp[g]),
      .d       (regD[g]),
      .q       (regQ[g])
    );
  end

  assign pinOut = regQ[ST_IDX];
  assign pinOe  = strobes.oeEn;
  assign fbOut  = strobes.fbSel ? regQ[FB_IDX] : regQ[ST_IDX];
  assign fbOutN = ~fbOut;
endmodule

// File: rtl/pld_io_cell.sv
module pld_io_cell
  import pld_io_cell_pkg::*;
#(
  parameter int NUM_SOP = 8
) (
  input  logic [NUM_SOP-1:0] sopTerms,
  input  logic               xorTerm,
  input  logic               stClkTerm,
  input  logic               stSetTerm,
  input  logic               stRstTerm,
  input  logic               fbClkTerm,
  input  logic               fbSetTerm,
  input  logic               fbRstTerm,
  input  logic               oeTerm,
  input  logic               globalOe,
  input  logic               cfgGlobalOe,
  input  logic               cfgFbFromPin,
  input  logic               pinIn,
  output logic               pinOut,
  output logic               pinOe,
  output logic               fbOut,
  output logic               fbOutN
);
  if (NUM_SOP < 4 || NUM_SOP > 12) begin : gBadSop
    $error("NUM_SOP must lie between 4 and 12");
  end

  cellStrobes_t strobes;

  pld_io_cell_ctrl uCtrl (
    .stSetTerm    (stSetTerm),
    .stRstTerm    (stRstTerm),
    .fbSetTerm    (fbSetTerm),
    .fbRstTerm    (fbRstTerm),
    .oeTerm       (oeTerm),
    .globalOe     (globalOe),
    .cfgGlobalOe  (cfgGlobalOe),
    .cfgFbFromPin (cfgFbFromPin),
    .strobes      (strobes)
  );

  pld_io_cell_dp #(.NUM_SOP(NUM_SOP)) uDp (
    .sopTerms  (sopTerms),
    .xorTerm   (xorTerm),
    .stClkTerm (stClkTerm),
    .fbClkTerm (fbClkTerm),
    .pinIn     (pinIn),
    .strobes   (strobes),
    .pinOut    (pinOut),
    .pinOe     (pinOe),
    .fbOut     (fbOut),
    .fbOutN    (fbOutN)
  );
endmodule

// File: rtl/pld_io_cell_chk.sv
module pld_io_cell_chk #(
  parameter int NUM_SOP = 8
) (
  input logic [NUM_SOP-1:0] sopTerms,
  input logic               xorTerm,
  input logic               stClkTerm,
  input logic               stSetTerm,
  input logic               stRstTerm,
  input logic               fbClkTerm,
  input logic               fbSetTerm,
  input logic               fbRstTerm,
  input logic               oeTerm,
  input logic               globalOe,
  input logic               cfgGlobalOe,
  input logic               cfgFbFromPin,
  input logic               pinOut,
  input logic               pinOe,
  input logic               fbOut,
  input logic               fbOutN
);
  always_comb begin
    if (cfgGlobalOe) begin
      AST_OE_GLOBAL: assert (pinOe == globalOe) else $error("global enable not routed"); // R5
    end else begin
      AST_OE_LOCAL: assert (pinOe == oeTerm) else $error("local enable not routed"); // R5
    end
    if (!$isunknown(fbOut)) begin
      AST_FB_COMPLEMENT: assert (fbOutN == ~fbOut) else $error("complement mismatch"); // R8
    end
  end

  AST_SET_DOMINATES: assert property (@(posedge stClkTerm)
    (stSetTerm && !stRstTerm) |-> pinOut) else $error("set lost to clock"); // R2
  AST_RESET_DOMINATES: assert property (@(posedge stClkTerm)
    (stRstTerm && !stSetTerm) |-> !pinOut) else $error("reset lost to clock"); // R2
  AST_BYPASS_FOLLOWS: assert property (@(posedge stClkTerm)
    (stSetTerm && stRstTerm) |-> (pinOut == ((|sopTerms) ^ xorTerm))) else $error("bypass broken"); // R3
  AST_FB_PIN_SET: assert property (@(posedge fbClkTerm)
    (cfgFbFromPin && fbSetTerm && !fbRstTerm) |-> fbOut) else $error("pin register set lost"); // R7
endmodule

bind pld_io_cell pld_io_cell_chk #(.NUM_SOP(NUM_SOP)) uChk (
  .sopTerms     (sopTerms),
  .xorTerm      (xorTerm),
  .stClkTerm    (stClkTerm),
  .stSetTerm    (stSetTerm),
  .stRstTerm    (stRstTerm),
  .fbClkTerm    (fbClkTerm),
  .fbSetTerm    (fbSetTerm),
  .fbRstTerm    (fbRstTerm),
  .oeTerm       (oeTerm),
  .globalOe     (globalOe),
  .cfgGlobalOe  (cfgGlobalOe),
  .cfgFbFromPin (cfgFbFromPin),
  .pinOut       (pinOut),
  .pinOe        (pinOe),
  .fbOut        (fbOut),
  .fbOutN       (fbOutN)
);

// File: tb/pld_io_cell_test.sv
module pld_io_cell_test;
  localparam int N = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [N-1:0] sop = '0;
  logic xorT = 0, sClk = 0, sSet = 0, sRst = 0, fClk = 0, fSet = 0, fRst = 0;
  logic oeT = 0, gOe = 0, cfgG = 0, cfgP = 0, pin = 0;
  logic pOut, pOe, fb, fbN;

  int checks = 0;
  int fails = 0;
  string phase = "R2 reset";
  bit started = 0;
  bit stStore = 0;
  bit fbStore = 0;

  pld_io_cell #(.NUM_SOP(N)) uut (
    .sopTerms(sop), .xorTerm(xorT),
    .stClkTerm(sClk), .stSetTerm(sSet), .stRstTerm(sRst),
    .fbClkTerm(fClk), .fbSetTerm(fSet), .fbRstTerm(fRst),
    .oeTerm(oeT), .globalOe(gOe), .cfgGlobalOe(cfgG), .cfgFbFromPin(cfgP),
    .pinIn(pin), .pinOut(pOut), .pinOe(pOe), .fbOut(fb), .fbOutN(fbN)
  );

  function automatic bit stateD();
    return (sop != '0) ^ xorT;
  endfunction
  function automatic bit expPin();
    return (sSet && sRst) ? stateD() : stStore;
  endfunction
  function automatic bit expPinReg();
    return (fSet && fRst) ? pin : fbStore;
  endfunction
  function automatic bit expFb();
    return cfgP ? expPinReg() : expPin();
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // model: a lone set or reset term overwrites the stored value
  task automatic settle();
    if (sSet ^ sRst) stStore = sSet;
    if (fSet ^ fRst) fbStore = fSet;
  endtask

  task automatic drive();
    @(posedge clk);
    #1;
  endtask

  task automatic pulseSt();
    drive();
    sClk = 1;
    if (!(sSet ^ sRst)) stStore = stateD();
    drive();
    sClk = 0;
  endtask

  task automatic pulseFb();
    drive();
    fClk = 1;
    if (!(fSet ^ fRst)) fbStore = pin;
    drive();
    fClk = 0;
  endtask

  task automatic look(string tag, logic exp);
    @(negedge clk);
    chk(tag, pOut, exp);
  endtask

  task automatic lookFb(string tag, logic exp);
    @(negedge clk);
    chk(tag, fb, exp);
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk({phase, " pinOut"}, pOut, expPin());
      chk({phase, " R5 pinOe"}, pOe, cfgG ? gOe : oeT);
      chk({phase, " R7 fbOut"}, fb, expFb());
      chk({phase, " R8 fbOutN"}, fbN, ~expFb());
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #(4 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog phase=%s actual=running expected=done", phase);
    summary();
    $finish;
  end

  initial begin
    // R2 reset state through the reset terms
    drive();
    sRst = 1; fRst = 1; settle();
    started = 1;
    look("R2 reset pinOut", 1'b0);
    cfgP = 1;
    lookFb("R2 reset pin register", 1'b0);
    drive();
    sRst = 0; fRst = 0; cfgP = 0; settle();

    // R1 each term alone, both polarities
    phase = "R1";
    for (int i = 0; i < N; i++) begin
      drive(); sop = N'(1) << i; xorT = 0;
      pulseSt(); look("R1 single term", 1'b1);
      drive(); xorT = 1;
      pulseSt(); look("R1 single term inverted", 1'b0);
    end
    drive(); sop = '0; xorT = 1;
    pulseSt(); look("R1 no terms xor high", 1'b1);
    drive(); xorT = 0;
    pulseSt(); look("R1 no terms", 1'b0);
    drive(); sop = '1;
    pulseSt(); look("R1 all terms", 1'b1);

    // R2 set-only / reset-only win over the clock
    phase = "R2";
    drive(); sop = '0; xorT = 0;
    drive(); sSet = 1; settle();
    look("R2 set async", 1'b1);
    pulseSt(); look("R2 clock ignored under set", 1'b1);
    drive(); sSet = 0; settle();
    drive(); sop = 5'b00100;
    drive(); sRst = 1; settle();
    look("R2 reset async", 1'b0);
    pulseSt(); look("R2 clock ignored under reset", 1'b0);
    drive(); sRst = 0; settle();

    // R3 bypass
    phase = "R3";
    drive(); sop = '0; xorT = 0;
    drive(); sSet = 1; sRst = 1; settle();
    look("R3 bypass low", 1'b0);
    drive(); xorT = 1;
    look("R3 bypass follows xor", 1'b1);
    drive(); sop = 5'b10000;
    look("R3 bypass follows sum", 1'b0);
    drive(); xorT = 0;
    pulseSt();
    drive(); sSet = 0; sRst = 0; settle();
    look("R3 drop both keeps clocked value", 1'b1);
    drive(); sop = '0; sSet = 1; sRst = 1; settle();
    look("R3 bypass again", 1'b0);
    drive(); sSet = 0; settle();
    look("R3 drop set leaves reset", 1'b0);
    drive(); sRst = 0; settle();
    drive(); sSet = 1; sRst = 1; settle();
    drive(); sRst = 0; settle();
    look("R3 drop reset leaves set", 1'b1);
    drive(); sSet = 0; settle();

    // R4 pin register
    phase = "R4";
    drive(); cfgP = 1; pin = 1;
    pulseFb(); lookFb("R4 pin captured", 1'b1);
    drive(); pin = 0;
    lookFb("R4 pin held without clock", 1'b1);
    pulseFb(); lookFb("R4 pin captured low", 1'b0);
    drive(); fSet = 1; settle();
    lookFb("R4 set", 1'b1);
    pulseFb(); lookFb("R4 clock ignored under set", 1'b1);
    drive(); fSet = 0; fRst = 1; settle();
    lookFb("R4 reset", 1'b0);
    drive(); fSet = 1; settle();
    drive(); pin = 1;
    lookFb("R4 bypass follows pin", 1'b1);
    drive(); pin = 0;
    lookFb("R4 bypass follows pin low", 1'b0);
    drive(); fSet = 0; fRst = 0; settle();

    // R5 enable source
    phase = "R5";
    drive(); cfgG = 1; gOe = 1; oeT = 0;
    @(negedge clk); chk("R5 global high", pOe, 1'b1);
    drive(); gOe = 0; oeT = 1;
    @(negedge clk); chk("R5 global low ignores term", pOe, 1'b0);
    drive(); cfgG = 0;
    @(negedge clk); chk("R5 local term", pOe, 1'b1);
    drive(); gOe = 1; oeT = 0;
    @(negedge clk); chk("R5 local ignores global", pOe, 1'b0);

    // R6 pin as input while released
    phase = "R6";
    drive(); pin = 1;
    pulseFb(); lookFb("R6 input capture with driver off", 1'b1);

    // R7 feedback selection
    phase = "R7";
    drive(); sop = '0; xorT = 0;
    pulseSt();
    lookFb("R7 pin register selected", 1'b1);
    drive(); cfgP = 0;
    lookFb("R7 state register selected", 1'b0);
    drive(); sSet = 1; sRst = 1; xorT = 1; settle();
    lookFb("R7 state bypass fed back", 1'b1);
    drive(); sSet = 0; sRst = 0; settle();
    @(negedge clk); chk("R8 complement", fbN, ~fb);

    drive(); drive();
    started = 0;
    summary();
    $finish;
  end
endmodule